// File: doc/BRIEF.md
# Successive-Approximation Converter Bus Controller

This block is the digital controller for a 10-bit successive-approximation converter that a processor addresses like a memory-mapped peripheral. The processor starts a conversion by pulsing a write strobe while chip-select is low. The controller then switches the analog front end from track to hold. It runs a binary search one bit per clock, from the most significant bit down. For each bit it presents a trial code to the external DAC and reads a single comparator bit back.

When the search ends, the result is captured in an output latch. The active-low completion flag drops in that same cycle, and the front end returns to tracking. A chip-selected read drives the latched code through the data-bus drive enable. The falling edge of that read raises the completion flag again.

The bus strobes are asynchronous. Each qualified strobe passes through a two-flop synchronizer before its edge is detected in the conversion clock domain. The only exception is the bus drive enable, which is decoded directly from the pins so that data appears as soon as the read is asserted.

Top module: `sar_bus_ctrl`

## Requirements
- R1: With `csN` high, a write pulse starts no conversion (`sampleHold` stays 0), and a read pulse neither asserts `busOe` nor raises `eocN`.
- R2: The rising edge of `wrN` while `csN` is low starts a conversion. `sampleHold` goes to 1 (hold) and `eocN` goes to 1 within a few clocks of that edge.
- R3: Counted in clock edges, `eocN` falls exactly WIDTH+1 cycles after `sampleHold` rises. `sampleHold` returns to 0 (track) on that same edge and stays 0 until the next start.
- R4: For each bit, from bit WIDTH-1 down to bit 0, the trial bit is kept when `cmpHigh`=1 (input at or above the trial level) and cleared otherwise. The result therefore equals the input code, with `busData[0]` as the LSB.
- R5: A comparator stuck at 1 gives all ones (1023), and one stuck at 0 gives all zeros.
- R6: The output latch loads only on the `eocN` falling edge. A read during a later conversion still returns the previous result.
- R7: The falling edge of `rdN` while `csN` is low returns `eocN` to 1.
- R8: `busOe` is 1 in the same cycle that both `csN` and `rdN` are low, and 0 otherwise. While it is 1, `busData` holds the latched result.
- R9: A qualified write that arrives during an active conversion is ignored. The conversion length and result are unchanged.
- R10: After reset, `eocN`=1, `sampleHold`=0 and `busOe`=0 (with strobes idle).
- R11: In the first hold cycle, `trialCode` has only bit WIDTH-1 set (512 by default).

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| wrN | input | 1 | Write strobe, active low; a rising edge starts a conversion |
| rdN | input | 1 | Read strobe, active low |
| cmpHigh | input | 1 | Comparator: 1 when the input is at or above the trial level |
| sampleHold | output | 1 | Front-end control: 1 = hold, 0 = track |
| trialCode | output | WIDTH | Trial code to the DAC |
| eocN | output | 1 | Completion flag, active low |
| busData | output | WIDTH | Latched result toward the data pads |
| busOe | output | 1 | Data-pad drive enable; the pads are high-impedance when it is 0 |

## Verification
The bench sweeps all 1024 analog input codes through a comparator model in the bench. This shows whether each bit decision keeps or clears the right trial bit, and whether bits are weighted and ordered correctly. Stuck-high and stuck-low comparators check the two rails independently of the trial-code arithmetic. Separate patterns change the strobe sequencing while the input code is held known:
- a write without chip-select;
- a read without chip-select;
- a write in the middle of a conversion;
- a read during a second conversion.

Each of these shows whether a stray edge restarts the search, clears the flag, or disturbs the latch.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_TRACK = 2'd0,
    ST_CONV  = 2'd1,
    ST_FIN   = 2'd2
  } sarState_t;

  typedef struct packed {
    logic init;
    logic step;
    logic latch;
  } sarStrobe_t;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int BITS   = 2,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [BITS-1:0] d,
  output logic [BITS-1:0] q
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < BITS; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[LAST];
  end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrAct,
  input  logic       rdAct,
  output sarStrobe_t strobe,
  output logic       sampleHold,
  output logic       eocN
);
  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(WIDTH - 1);

  sarState_t   state;
  logic [CW-1:0] cnt;
  logic        wrPrev, rdPrev;
  logic        startP, readP;

  // write completes when the qualified write deasserts; read begins when it asserts
  assign startP = wrPrev & ~wrAct;
  assign readP  = ~rdPrev & rdAct;

  always_comb begin
    strobe       = '0;
    strobe.init  = (state == ST_TRACK) && startP;
    strobe.step  = (state == ST_CONV);
    strobe.latch = (state == ST_FIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_TRACK;
      cnt        <= '0;
      wrPrev     <= 1'b0;
      rdPrev     <= 1'b0;
      sampleHold <= 1'b0;
      eocN       <= 1'b1;
    end else begin
      wrPrev <= wrAct;
      rdPrev <= rdAct;
      if (readP) eocN <= 1'b1;
      unique case (state)
        ST_TRACK: if (startP) begin
          state      <= ST_CONV;
          cnt        <= LAST_CNT;
          sampleHold <= 1'b1;
          eocN       <= 1'b1;
        end
        ST_CONV: begin
          if (cnt == '0) state <= ST_FIN;
          else           cnt   <= cnt - 1'b1;
        end
        ST_FIN: begin
          state      <= ST_TRACK;
          sampleHold <= 1'b0;
          eocN       <= 1'b0;
        end
        default: state <= ST_TRACK;
      endcase
    end
  end

  // R3: track resumes on the same edge the flag falls
  a_r3_track_at_eoc: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eocN) |-> !sampleHold);
  // R9: an active search counts down undisturbed by new writes
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV && cnt != '0) |=> (state == ST_CONV && cnt == CW'($past(cnt) - 1'b1)));
  // R7: a qualified read edge raises the flag unless the latch fires then
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (readP && state != ST_FIN) |=> eocN);
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  sarStrobe_t       strobe,
  input  logic             cmpHigh,
  output logic [WIDTH-1:0] trialCode,
  output logic [WIDTH-1:0] result
);
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trialCode <= '0;
      ptr       <= '0;
      result    <= '0;
    end else begin
      if (strobe.init) begin
        trialCode <= MSB_ONLY;
        ptr       <= MSB_ONLY;
      end else if (strobe.step) begin
        trialCode <= (trialCode & ~ptr) | (cmpHigh ? ptr : '0) | (ptr >> 1);
        ptr       <= ptr >> 1;
      end
      if (strobe.latch) result <= trialCode;
    end
  end

  // R4: at most one bit under test at any time
  a_r4_ptr_onehot: assert property (@(posedge clk) disable iff (!rstN) $onehot0(ptr));
  // R6: latch changes only on the completion strobe
  a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latch |=> $stable(result));
  // R11: search opens with only the top bit set
  a_r11_first_trial: assert property (@(posedge clk) disable iff (!rstN)
    strobe.init |=> (trialCode == MSB_ONLY));
endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             wrN,
  input  logic             rdN,
  input  logic             cmpHigh,
  output logic             sampleHold,
  output logic [WIDTH-1:0] trialCode,
  output logic             eocN,
  output logic [WIDTH-1:0] busData,
  output logic             busOe
);
  logic [1:0]  rawAct, syncAct;
  sarStrobe_t  strobe;

  assign rawAct = {~csN & ~rdN, ~csN & ~wrN};
  assign busOe  = ~csN & ~rdN;

  sar_sync #(.BITS(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rstN (rstN), .d (rawAct), .q (syncAct)
  );

  sar_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk (clk), .rstN (rstN),
    .wrAct (syncAct[0]), .rdAct (syncAct[1]),
    .strobe (strobe), .sampleHold (sampleHold), .eocN (eocN)
  );

  sar_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk (clk), .rstN (rstN), .strobe (strobe), .cmpHigh (cmpHigh),
    .trialCode (trialCode), .result (busData)
  );

  // R8: pads never driven without chip-select
  a_r8_no_drive_unselected: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !busOe);
endmodule

// File: tb/test_sar_bus_ctrl.sv
module test_sar_bus_ctrl;
  localparam int W = 10;
  localparam int FULL = (1 << W) - 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic csN = 1'b1, wrN = 1'b1, rdN = 1'b1;
  logic cmpHigh, sampleHold, eocN, busOe;
  logic [W-1:0] trialCode, busData;
  int vin = 0;
  int mode = 0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign cmpHigh = (mode == 1) ? 1'b1 : (mode == 2) ? 1'b0 : (vin >= int'(trialCode));

  sar_bus_ctrl i_sar_bus_ctrl (
    .clk (clk), .rstN (rstN), .csN (csN), .wrN (wrN), .rdN (rdN), .cmpHigh (cmpHigh),
    .sampleHold (sampleHold), .trialCode (trialCode), .eocN (eocN),
    .busData (busData), .busOe (busOe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doWrite(input bit sel);
    @(negedge clk); csN = ~sel; wrN = 1'b0;
    repeat (2) @(negedge clk);
    wrN = 1'b1; csN = 1'b1;
  endtask

  // start, follow the search, return hold-to-eoc length
  task automatic convert(input bit midWrite, output int len);
    int t;
    len = -1;
    doWrite(1'b1);
    t = 0;
    while (!sampleHold && t < 20) begin @(negedge clk); t++; end
    check(sampleHold == 1'b1 && eocN == 1'b1, "R2 hold/eoc after write", sampleHold, 1);
    check(trialCode == (1 << (W-1)), "R11 first trial", trialCode, 1 << (W-1));
    len = 0;
    while (eocN && len < 50) begin
      @(negedge clk); len++;
      if (midWrite && len == 2) begin
        csN = 1'b0; wrN = 1'b0;
      end
      if (midWrite && len == 4) begin
        wrN = 1'b1; csN = 1'b1;
      end
    end
    check(sampleHold == 1'b0, "R3 track at eoc", sampleHold, 0);
  endtask

  task automatic doRead(input int exp, input string tag);
    @(negedge clk); csN = 1'b0; rdN = 1'b0;
    #1;
    check(busOe == 1'b1, "R8 drive enable", busOe, 1);
    check(int'(busData) == exp, tag, busData, exp);
    repeat (3) @(negedge clk);
    rdN = 1'b1; csN = 1'b1;
    repeat (4) @(negedge clk);
    check(eocN == 1'b1, "R7 read clears eoc", eocN, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int len;
    repeat (3) @(negedge clk);
    check(eocN == 1'b1 && sampleHold == 1'b0 && busOe == 1'b0, "R10 reset state",
          {eocN, sampleHold, busOe}, 3'b100);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(eocN == 1'b1 && sampleHold == 1'b0, "R10 after release", {eocN, sampleHold}, 2'b10);

    // R1: unselected write
    doWrite(1'b0);
    repeat (10) @(negedge clk);
    check(sampleHold == 1'b0, "R1 unselected write", sampleHold, 0);

    // full sweep of input codes (R3, R4)
    for (int v = 0; v <= FULL; v++) begin
      vin = v;
      convert(1'b0, len);
      check(len == W + 1, "R3 conversion length", len, W + 1);
      doRead(v, "R4 result code");
    end

    // R5: stuck comparators
    mode = 1; convert(1'b0, len); doRead(FULL, "R5 all ones");
    mode = 2; convert(1'b0, len); doRead(0, "R5 all zeros");
    mode = 0;

    // R9: write during conversion
    vin = 345;
    convert(1'b1, len);
    check(len == W + 1, "R9 length with mid write", len, W + 1);
    repeat (10) @(negedge clk);
    check(sampleHold == 1'b0 && eocN == 1'b0, "R9 no restart", sampleHold, 0);

    // R1: unselected read leaves eoc low and pads off
    @(negedge clk); rdN = 1'b0;
    #1 check(busOe == 1'b0, "R1 unselected read enable", busOe, 0);
    repeat (3) @(negedge clk); rdN = 1'b1;
    repeat (4) @(negedge clk);
    check(eocN == 1'b0, "R1 unselected read keeps eoc", eocN, 0);
    doRead(345, "R9 result kept");

    // R6: latch keeps old result during the next conversion
    vin = 77;
    convert(1'b0, len);
    vin = 900;
    doWrite(1'b1);
    repeat (5) @(negedge clk);
    check(sampleHold == 1'b1, "R6 second conversion running", sampleHold, 1);
    @(negedge clk); csN = 1'b0; rdN = 1'b0;
    #1 check(int'(busData) == 77, "R6 old result during conversion", busData, 77);
    @(negedge clk); rdN = 1'b1; csN = 1'b1;
    len = 0;
    while (eocN && len < 50) begin @(negedge clk); len++; end
    doRead(900, "R6 new result after eoc");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule